// File: doc/BRIEF.md
# Group-Owned Register Write Filter

This block holds one 32-bit per-bank configuration word and decides, byte by byte, which part of a write is allowed to land in it. The word is divided into four 8-bit groups. Each group has a 2-bit owner code, and only a requester whose ID equals that code may change the group. A single write strobe can therefore be fully accepted, partly accepted or thrown away entirely, depending on who sent it and how ownership is currently arranged.

Ownership lives in two owner-select registers, a low-bit register and a high-bit register. They are written through the same strobe as the configuration word and keep only the one bit at the base of each group. Owner code values are 0 for the main CPU, 1 for the LPC host, 2 for the coprocessor and 3 for a reserved source. A combinational read port returns any of the three registers, and the filtered configuration word is also driven out continuously.

Top module: `group_write_filter`

## Requirements
- R1: After reset the configuration word and both owner registers read 0, so every group is owned by code 0.
- R2: A write to an owner register stores only bits 0, 8, 16 and 24 of the data (mask 0x01010101); readback returns exactly that masked value with every other bit 0.
- R3: The owner code of group g (bits 8g+7..8g) is {high register bit 8g, low register bit 8g}; on a configuration write a group whose code equals the requester ID takes the matching byte of the write data.
- R4: With all groups at code 0, a configuration write from requester 0 replaces the whole word.
- R5: On a configuration write, every group whose code differs from the requester ID keeps its previous byte.
- R6: Requester ID 3 changes only groups whose owner code is 3; with no such group its write leaves the word unchanged.
- R7: A configuration write becomes visible on the clock edge that ends the strobe cycle, not before; with the strobe low, no register changes whatever the data, select or requester inputs do.
- R8: Owner register writes are accepted from any requester ID and never alter the configuration word.
- R9: Register select encoding is 0 = configuration word, 1 = owner low, 2 = owner high; select 3 writes nothing and reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe, one write per cycle it is high |
| wrSel | input | 2 | Target register of the write (R9 encoding) |
| reqId | input | 2 | ID of the requester issuing the write |
| wrData | input | DATA_W (32) | Write data word |
| rdSel | input | 2 | Register returned on rdData (R9 encoding) |
| rdData | output | DATA_W (32) | Combinational readback |
| cfgValue | output | DATA_W (32) | Current filtered configuration word |

## Verification
Configuration writes are issued first with every group owned by code 0, from the owning and from a foreign requester, which separates a working merge from one that ignores the requester. Ownership is then spread so that the four groups carry the four different codes, and one write per requester ID must touch exactly one byte, which exposes swapped owner bits, wrong group slicing and a reserved ID that matches too much or too little. Owner writes with all-ones data and with scattered bits show whether the mask keeps precisely the group base bits, and a pre-edge sample during every strobe distinguishes a registered update from a combinational one.

// File: rtl/gfw_pkg.sv
package gfw_pkg;

  // Register select encoding shared by write and read paths.
  typedef enum logic [1:0] {
    SEL_CFG    = 2'd0,
    SEL_OWN_LO = 2'd1,
    SEL_OWN_HI = 2'd2,
    SEL_NONE   = 2'd3
  } regSelE;

  // Requester / owner code values.
  typedef enum logic [1:0] {
    REQ_CPU    = 2'd0,
    REQ_HOST   = 2'd1,
    REQ_COPROC = 2'd2,
    REQ_RSVD   = 2'd3
  } reqIdE;

  // Strobes from control to datapath.
  typedef struct packed {
    logic cfgWr;
    logic loWr;
    logic hiWr;
  } wrStrbT;

endpackage

// File: rtl/gfw_ctrl.sv
module gfw_ctrl
  import gfw_pkg::*;
#(
  parameter int NGROUP = 4
) (
  input  logic                   wrEn,
  input  logic [1:0]             wrSel,
  input  logic [1:0]             reqId,
  input  logic [NGROUP-1:0][1:0] ownCode,
  output wrStrbT                 strb,
  output logic [NGROUP-1:0]      groupWe
);

  // Decode the target register of an active write.
  always_comb begin
    strb = '0;
    if (wrEn) begin
      unique case (wrSel)
        SEL_CFG:    strb.cfgWr = 1'b1;
        SEL_OWN_LO: strb.loWr  = 1'b1;
        SEL_OWN_HI: strb.hiWr  = 1'b1;
        default:    strb = '0;
      endcase
    end
  end

  // Per-group ownership match gates the configuration byte enables.
  for (genvar g = 0; g < NGROUP; g++) begin : gMatch
    logic ownerHit;
    assign ownerHit   = (ownCode[g] == reqId);
    assign groupWe[g] = strb.cfgWr & ownerHit;
  end

endmodule

// File: rtl/gfw_datapath.sv
module gfw_datapath
  import gfw_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int GROUP_W = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  wrStrbT                        strb,
  input  logic [DATA_W/GROUP_W-1:0]     groupWe,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [1:0]                    rdSel,
  output logic [DATA_W-1:0]             cfgQ,
  output logic [DATA_W-1:0]             ownLoWord,
  output logic [DATA_W-1:0]             ownHiWord,
  output logic [DATA_W/GROUP_W-1:0][1:0] ownCode,
  output logic [DATA_W-1:0]             rdData
);

  localparam int NGROUP = DATA_W / GROUP_W;

  // Only one bit per group is stored for each owner register.
  logic [NGROUP-1:0] ownLoBits;
  logic [NGROUP-1:0] ownHiBits;
  logic [GROUP_W-1:0] cfgByte [NGROUP];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ownLoBits <= '0;
      ownHiBits <= '0;
    end else begin
      for (int g = 0; g < NGROUP; g++) begin
        if (strb.loWr) ownLoBits[g] <= wrData[g*GROUP_W];
        if (strb.hiWr) ownHiBits[g] <= wrData[g*GROUP_W];
      end
    end
  end

  // One byte-enabled register per group.
  for (genvar g = 0; g < NGROUP; g++) begin : gCfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           cfgByte[g] <= '0;
      else if (groupWe[g]) cfgByte[g] <= wrData[g*GROUP_W +: GROUP_W];
    end
    assign cfgQ[g*GROUP_W +: GROUP_W] = cfgByte[g];
    assign ownCode[g] = {ownHiBits[g], ownLoBits[g]};
  end

  // Expand stored owner bits back to full-width readback words.
  always_comb begin
    ownLoWord = '0;
    ownHiWord = '0;
    for (int g = 0; g < NGROUP; g++) begin
      ownLoWord[g*GROUP_W] = ownLoBits[g];
      ownHiWord[g*GROUP_W] = ownHiBits[g];
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_CFG:    rdData = cfgQ;
      SEL_OWN_LO: rdData = ownLoWord;
      SEL_OWN_HI: rdData = ownHiWord;
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/group_write_filter.sv
module group_write_filter
  import gfw_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int GROUP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [1:0]        reqId,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] cfgValue
);

  localparam int NGROUP = DATA_W / GROUP_W;

  wrStrbT                  strb;
  logic [NGROUP-1:0]       groupWe;
  logic [NGROUP-1:0][1:0]  ownCode;
  logic [DATA_W-1:0]       ownLoWord;
  logic [DATA_W-1:0]       ownHiWord;

  gfw_ctrl #(.NGROUP(NGROUP)) uCtrl (
    .wrEn    (wrEn),
    .wrSel   (wrSel),
    .reqId   (reqId),
    .ownCode (ownCode),
    .strb    (strb),
    .groupWe (groupWe)
  );

  gfw_datapath #(.DATA_W(DATA_W), .GROUP_W(GROUP_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .groupWe   (groupWe),
    .wrData    (wrData),
    .rdSel     (rdSel),
    .cfgQ      (cfgValue),
    .ownLoWord (ownLoWord),
    .ownHiWord (ownHiWord),
    .ownCode   (ownCode),
    .rdData    (rdData)
  );

endmodule

// File: rtl/gfw_checker.sv
module gfw_checker #(
  parameter int DATA_W  = 32,
  parameter int GROUP_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [1:0]        wrSel,
  input logic [1:0]        reqId,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] cfgValue,
  input logic [DATA_W-1:0] ownLoWord,
  input logic [DATA_W-1:0] ownHiWord
);

  localparam int NGROUP = DATA_W / GROUP_W;

  function automatic logic [DATA_W-1:0] baseBits();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int g = 0; g < NGROUP; g++) m[g*GROUP_W] = 1'b1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] KEEP_MASK = baseBits();

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rstN |=> (cfgValue == '0 && ownLoWord == '0 && ownHiWord == '0)); // R1

  AST_OWN_LO_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd1) |=> ownLoWord == ($past(wrData) & KEEP_MASK)); // R2

  AST_OWN_HI_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd2) |=> ownHiWord == ($past(wrData) & KEEP_MASK)); // R2

  AST_FULL_CPU_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd0 && reqId == 2'd0 && ownLoWord == '0 && ownHiWord == '0)
      |=> cfgValue == $past(wrData)); // R4

  AST_RSVD_NO_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd0 && reqId == 2'd3 && (ownLoWord & ownHiWord) == '0)
      |=> $stable(cfgValue)); // R6

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(cfgValue) && $stable(ownLoWord) && $stable(ownHiWord))); // R7

  AST_OWNER_WR_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel != 2'd0) |=> $stable(cfgValue)); // R8

  AST_NONE_SEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel == 2'd3) |=> ($stable(ownLoWord) && $stable(ownHiWord))); // R9

  for (genvar g = 0; g < NGROUP; g++) begin : gGrp
    AST_GROUP_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrSel == 2'd0 && {ownHiWord[g*GROUP_W], ownLoWord[g*GROUP_W]} == reqId)
        |=> cfgValue[g*GROUP_W +: GROUP_W] == $past(wrData[g*GROUP_W +: GROUP_W])); // R3

    AST_GROUP_KEPT: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrSel == 2'd0 && {ownHiWord[g*GROUP_W], ownLoWord[g*GROUP_W]} != reqId)
        |=> $stable(cfgValue[g*GROUP_W +: GROUP_W])); // R5
  end

endmodule

bind group_write_filter gfw_checker #(.DATA_W(DATA_W), .GROUP_W(GROUP_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrSel     (wrSel),
  .reqId     (reqId),
  .wrData    (wrData),
  .cfgValue  (cfgValue),
  .ownLoWord (ownLoWord),
  .ownHiWord (ownHiWord)
);

// File: tb/tb_group_write_filter.sv
module tb_group_write_filter;

  localparam int DW = 32;
  localparam logic [DW-1:0] BASE_MASK = 32'h0101_0101;
  localparam time WATCHDOG = 20ns * 20000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [1:0]    wrSel = 2'd0;
  logic [1:0]    reqId = 2'd0;
  logic [DW-1:0] wrData = '0;
  logic [1:0]    rdSel = 2'd0;
  logic [DW-1:0] rdData;
  logic [DW-1:0] cfgValue;

  always #10ns clk = ~clk;

  group_write_filter dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .reqId(reqId),
    .wrData(wrData), .rdSel(rdSel), .rdData(rdData), .cfgValue(cfgValue)
  );

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } itemT;

  itemT sbq[$];
  int compared = 0;
  int mismatched = 0;
  bit timedOut = 1'b0;

  // Reference state built from the requirements.
  logic [DW-1:0] mCfg = '0, mLo = '0, mHi = '0;

  // Monitor: one scoreboard item per cycle, compared at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        itemT it;
        it = sbq.pop_front();
        compared++;
        if (rdData !== it.exp) begin
          mismatched++;
          $display("FAIL %s: actual %h expected %h", it.tag, rdData, it.exp);
        end
      end
    end
  end

  task automatic expectRead(input logic [1:0] sel, input logic [DW-1:0] exp, input string tag);
    @(posedge clk); #2ns;
    rdSel = sel;
    sbq.push_back('{exp, tag});
  endtask

  task automatic checkAll(input string tag);
    expectRead(2'd0, mCfg, {tag, " cfg"});
    expectRead(2'd1, mLo,  {tag, " ownLo"});
    expectRead(2'd2, mHi,  {tag, " ownHi"});
  endtask

  // Driver: one write strobe, plus an R7 pre-edge sample of the old word.
  task automatic doWrite(input logic [1:0] sel, input logic [1:0] req, input logic [DW-1:0] data);
    @(posedge clk); #2ns;
    wrEn = 1'b1; wrSel = sel; reqId = req; wrData = data;
    rdSel = 2'd0;
    sbq.push_back('{mCfg, "R7 pre-edge cfg unchanged"});
    case (sel)
      2'd0: for (int g = 0; g < DW/8; g++)
              if ({mHi[g*8], mLo[g*8]} == req) mCfg[g*8 +: 8] = data[g*8 +: 8];
      2'd1: mLo = data & BASE_MASK;
      2'd2: mHi = data & BASE_MASK;
      default: ;
    endcase
    @(posedge clk); #2ns;
    wrEn = 1'b0;
  endtask

  task automatic stimulus();
    repeat (3) @(posedge clk);
    #2ns rstN = 1'b1;
    // R1 reset state
    checkAll("R1 reset");
    @(negedge clk);
    compared++;
    if (cfgValue !== '0) begin
      mismatched++;
      $display("FAIL R1 cfgValue port: actual %h expected %h", cfgValue, 32'h0);
    end
    // R4 full write by owner of every group
    doWrite(2'd0, 2'd0, 32'hA5C3_1E77);
    expectRead(2'd0, mCfg, "R4 full cpu write");
    // R5 foreign requester, all groups owned by code 0
    doWrite(2'd0, 2'd1, 32'h0F0F_0F0F);
    expectRead(2'd0, mCfg, "R5 host write discarded");
    // R2 owner mask with all-ones, R8 owner write from reserved requester
    doWrite(2'd1, 2'd3, 32'hFFFF_FFFF);
    expectRead(2'd1, 32'h0101_0101, "R2 ownLo masked all-ones");
    expectRead(2'd0, mCfg, "R8 cfg kept over owner write");
    // Codes g0=0, g1=1, g2=2, g3=3
    doWrite(2'd1, 2'd2, 32'hFE00_01FE | 32'h0100_0100);
    doWrite(2'd2, 2'd1, 32'hFFFF_0000);
    checkAll("R2 R8 owner layout");
    // R3 one group per requester
    doWrite(2'd0, 2'd0, 32'h1122_3344);
    expectRead(2'd0, mCfg, "R3 cpu byte0 only");
    doWrite(2'd0, 2'd1, 32'h5566_7788);
    expectRead(2'd0, mCfg, "R3 host byte1 only");
    doWrite(2'd0, 2'd2, 32'h99AA_BBCC);
    expectRead(2'd0, mCfg, "R3 coproc byte2 only");
    doWrite(2'd0, 2'd3, 32'hDDEE_FF00);
    expectRead(2'd0, mCfg, "R6 reserved byte3 only");
    // Codes g0=0, g1=1, g2=0, g3=1
    doWrite(2'd2, 2'd0, 32'h0000_0000);
    doWrite(2'd0, 2'd3, 32'hFFFF_FFFF);
    expectRead(2'd0, mCfg, "R6 reserved no owner");
    doWrite(2'd0, 2'd1, 32'h0000_0000);
    expectRead(2'd0, mCfg, "R5 host partial two groups");
    // R7 strobe low, inputs toggling
    @(posedge clk); #2ns;
    wrSel = 2'd0; reqId = 2'd0; wrData = 32'hFFFF_FFFF;
    @(posedge clk); #2ns;
    wrSel = 2'd1; wrData = 32'hFFFF_FFFF;
    @(posedge clk); #2ns;
    wrSel = 2'd2;
    checkAll("R7 no strobe");
    // R9 select 3
    doWrite(2'd3, 2'd0, 32'hFFFF_FFFF);
    checkAll("R9 sel3 write");
    expectRead(2'd3, 32'h0, "R9 sel3 read zero");
    repeat (2) @(negedge clk);
  endtask

  initial begin
    fork
      stimulus();
      begin
        #(WATCHDOG);
        timedOut = 1'b1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule